// File: doc/BRIEF.md
# Three-Way Pairing Join Element

This block is a clocked model of a self-timed join element with three event lines in and three event lines out. An event is a one-cycle pulse on an input line. A lone event is remembered as pending. When an event then arrives on a different line, the block emits one pulse on the output line that belongs to that unordered pair and forgets both events. The output that belongs to a pair is always the line whose index is the one not in the pair. In 1-based terms, inputs i and j drive output 6-i-j.

A fault injection port marks input lines as permanently stuck at logic 1. A line stays marked until reset. The block then shows the output pattern of the faulty element, so a test environment can check fault signatures against a known model.

In the requirements below, lines are numbered 0..2, vector bit n is line n, and succ(k) = (k+1) mod 3 and pred(k) = (k+2) mod 3. "Next cycle" means the output is visible after the clock edge that samples the input.

Top module: `tri_pair_join`

## Requirements
- R1: While `rst` is high at a clock edge, `ev_out` and `dup_err` are 0 after that edge, and all pending events are cleared.
- R2: With no fault marked, a single event on one line gives no output pulse, and the line stays pending.
- R3: With no fault marked, an event on line b while line a (a≠b) is pending gives `ev_out` = one-hot bit (3-a-b) for exactly the next cycle. Both lines are then no longer pending.
- R4: With no fault marked and nothing pending, events on two lines in the same cycle pair at once, with the same output mapping as R3.
- R5: With no fault marked and nothing pending, events on all three lines together pair lines 0 and 1, giving `ev_out` = 3'b100. Line 2 stays pending.
- R6: With no fault marked, an event on a line that is already pending gives `dup_err` = 1 for the next cycle. That event is otherwise ignored: the line stays pending just once.
- R7: A pulse on `flt_set[k]` marks line k as stuck from the next cycle on. The mark is sticky and stays when `flt_set` returns to 0.
- R8: With exactly one line k marked, `ev_out[succ(k)]` is held at 1.
- R9: With exactly one line k marked, an event on line succ(k) gives a one-cycle pulse on `ev_out[pred(k)]`. An event on line pred(k) causes no visible change.
- R10: With exactly two lines marked, `ev_out` holds 1 only on the bit of the unmarked line, and events on any line have no effect.
- R11: With all three lines marked, `ev_out` stays 0 whatever events arrive.
- R12: Reset removes all fault marks, and afterwards the block pairs events normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 3 | One-cycle event pulses, one bit per input line |
| flt_set | input | 3 | Pulse marks the matching input line as stuck at 1 |
| ev_out | output | 3 | Output event pulses, or held levels under fault |
| dup_err | output | 1 | One-cycle flag for a repeated event on a pending line |

## Verification
The bench checks which pair wins when all three lines fire in one cycle. A design with the wrong priority would pulse a different output, or drop the leftover pending line, so the follow-up event would not pair. It also repeats an event on a line that is already pending, with and without a partner in the same cycle. A design that re-armed the line or pulsed early would show up on `ev_out` or `dup_err`. Each single-fault position is tested with events on the successor and on the predecessor line. Swapping succ and pred, or letting the absorbed event through, gives a wrong held or pulsed bit. The bench also checks that reset drops sticky fault marks.

// File: rtl/tpj_pkg.sv
package tpj_pkg;

    localparam int unsigned LINES = 3;

    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [1:0] {
        MODE_OK  = 2'd0,
        MODE_ONE = 2'd1,
        MODE_TWO = 2'd2,
        MODE_ALL = 2'd3
    } fault_mode_e;

    typedef struct packed {
        line_vec_t pulse;
        logic      dup;
    } join_res_t;

    function automatic int unsigned succ_line(input int unsigned k);
        return (k + 1) % LINES;
    endfunction

    function automatic int unsigned pred_line(input int unsigned k);
        return (k + LINES - 1) % LINES;
    endfunction

    // index of the line not contained in pair (a,b)
    function automatic int unsigned third_line(input int unsigned a, input int unsigned b);
        return (LINES * (LINES - 1) / 2) - a - b;
    endfunction

    function automatic fault_mode_e mode_of(input line_vec_t stuck);
        case ($countones(stuck))
            0:       return MODE_OK;
            1:       return MODE_ONE;
            2:       return MODE_TWO;
            default: return MODE_ALL;
        endcase
    endfunction

endpackage

// File: rtl/tpj_fault_reg.sv
module tpj_fault_reg
    import tpj_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_vec_t   flt_set,
    output line_vec_t   stuck_q,
    output line_vec_t   stuck_d,
    output fault_mode_e mode,
    output line_vec_t   level
);

    assign stuck_d = stuck_q | flt_set;

    always_ff @(posedge clk) begin
        if (rst) stuck_q <= '0;
        else     stuck_q <= stuck_d;
    end

    assign mode = mode_of(stuck_q);

    for (genvar o = 0; o < LINES; o++) begin : g_level
        // single stuck k holds output succ(k); two stuck hold the free line
        assign level[o] = ((mode == MODE_ONE) && stuck_q[pred_line(o)])
                        || ((mode == MODE_TWO) && !stuck_q[o]);
    end

    // R7: a fault mark never disappears without reset
    a_r7_sticky_marks: assert property (@(posedge clk) disable iff (rst)
        (|stuck_q) |=> ((stuck_q & $past(stuck_q)) == $past(stuck_q)));

endmodule

// File: rtl/tpj_pair_core.sv
module tpj_pair_core
    import tpj_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      flush,
    input  line_vec_t ev,
    output join_res_t res_q
);

    line_vec_t   pend_q;
    line_vec_t   pend_d;
    line_vec_t   avail;
    line_vec_t   clr;
    logic        found;
    int unsigned pick;
    join_res_t   res_d;

    always_comb begin
        avail = pend_q | ev;
        clr   = '0;
        found = 1'b0;
        pick  = 0;
        for (int unsigned a = 0; a < LINES; a++) begin
            for (int unsigned b = a + 1; b < LINES; b++) begin
                if (!found && avail[a] && avail[b]) begin
                    found  = 1'b1;
                    pick   = third_line(a, b);
                    clr[a] = 1'b1;
                    clr[b] = 1'b1;
                end
            end
        end
        pend_d      = flush ? '0 : (avail & ~clr);
        res_d.pulse = (en && found) ? line_vec_t'(1 << pick) : '0;
        res_d.dup   = en && (|(ev & pend_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            res_q  <= '0;
        end else begin
            pend_q <= pend_d;
            res_q  <= res_d;
        end
    end

    // R2: at most one line can be waiting
    a_r2_single_pending: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend_q));

    // R2: nothing pending and at most one event gives no pulse
    a_r2_no_lone_pulse: assert property (@(posedge clk) disable iff (rst)
        (en && pend_q == '0 && $countones(ev) <= 1) |=> (res_q.pulse == '0));

    // R4: two or more events together always fire exactly one output
    a_r4_same_cycle_pair: assert property (@(posedge clk) disable iff (rst)
        (en && !flush && pend_q == '0 && $countones(ev) >= 2) |=> $onehot(res_q.pulse));

    // R6: repeat on a pending line is flagged
    a_r6_dup_flag: assert property (@(posedge clk) disable iff (rst)
        (en && |(ev & pend_q)) |=> res_q.dup);

endmodule

// File: rtl/tpj_fault_path.sv
module tpj_fault_path
    import tpj_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fault_mode_e mode,
    input  line_vec_t   stuck,
    input  line_vec_t   ev,
    output line_vec_t   pulse_q
);

    line_vec_t pulse_d;

    for (genvar o = 0; o < LINES; o++) begin : g_path
        // stuck k with event on succ(k) pulses output pred(k); here k = succ(o)
        assign pulse_d[o] = (mode == MODE_ONE) && stuck[succ_line(o)] && ev[pred_line(o)];
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= pulse_d;
    end

    // R9: a faulty pulse only follows an event
    a_r9_pulse_needs_event: assert property (@(posedge clk) disable iff (rst)
        (ev == '0) |=> (pulse_q == '0));

endmodule

// File: rtl/tri_pair_join.sv
module tri_pair_join
    import tpj_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ev_in,
    input  logic [2:0] flt_set,
    output logic [2:0] ev_out,
    output logic       dup_err
);

    line_vec_t   stuck_q;
    line_vec_t   stuck_d;
    line_vec_t   level;
    line_vec_t   fpulse;
    fault_mode_e mode;
    join_res_t   core_res;

    tpj_fault_reg u_freg (
        .clk     (clk),
        .rst     (rst),
        .flt_set (flt_set),
        .stuck_q (stuck_q),
        .stuck_d (stuck_d),
        .mode    (mode),
        .level   (level)
    );

    tpj_pair_core u_core (
        .clk   (clk),
        .rst   (rst),
        .en    (mode == MODE_OK),
        .flush (|stuck_d),
        .ev    (ev_in),
        .res_q (core_res)
    );

    tpj_fault_path u_fpath (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .stuck   (stuck_q),
        .ev      (ev_in),
        .pulse_q (fpulse)
    );

    assign ev_out  = core_res.pulse | fpulse | level;
    assign dup_err = core_res.dup;

    // R11: all lines stuck silences every output
    a_r11_all_stuck_silent: assert property (@(posedge clk) disable iff (rst)
        (stuck_q == '1) |-> (ev_out == '0));

    // R10: two stuck lines hold exactly the free output
    a_r10_two_stuck_level: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TWO && $stable(stuck_q)) |-> (ev_out == ~stuck_q));

    // R8: single stuck line keeps at least one output high
    a_r8_single_stuck_level: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ONE) |-> (ev_out != '0));

endmodule

// File: tb/sim_tri_pair_join.sv
module sim_tri_pair_join;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2:0] out;
        logic       dup;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ev_in = '0;
    logic [2:0] flt_set = '0;
    logic [2:0] ev_out;
    logic       dup_err;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    tri_pair_join u0 (
        .clk     (clk),
        .rst     (rst),
        .ev_in   (ev_in),
        .flt_set (flt_set),
        .ev_out  (ev_out),
        .dup_err (dup_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step(input logic r, input logic [2:0] ev, input logic [2:0] fs,
                        input logic [2:0] eo, input logic ed, input string tag);
        exp_t it;
        @(negedge clk);
        rst     = r;
        ev_in   = ev;
        flt_set = fs;
        it.out  = eo;
        it.dup  = ed;
        it.tag  = tag;
        q.push_back(it);
    endtask

    // monitor: one expected item per clock edge, sampled just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_tests++;
                if (ev_out !== it.out || dup_err !== it.dup) begin
                    n_fail++;
                    $display("FAIL %s: ev_out=%b dup=%b expected ev_out=%b dup=%b",
                             it.tag, ev_out, dup_err, it.out, it.dup);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 3'b000, 3'b000, 3'b000, 0, "R1 reset");
        step(1, 3'b111, 3'b000, 3'b000, 0, "R1 reset ignores events");
        step(1, 3'b000, 3'b000, 3'b000, 0, "R1 reset");
        // R2 lone event held
        step(0, 3'b001, 3'b000, 3'b000, 0, "R2 lone event");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R2 idle");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R2 idle");
        // R3 pairs
        step(0, 3'b100, 3'b000, 3'b010, 0, "R3 pair 0,2");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R3 single-cycle pulse");
        step(0, 3'b010, 3'b000, 3'b000, 0, "R2 lone event");
        step(0, 3'b001, 3'b000, 3'b100, 0, "R3 pair 1,0");
        step(0, 3'b010, 3'b000, 3'b000, 0, "R2 lone event");
        step(0, 3'b100, 3'b000, 3'b001, 0, "R3 pair 1,2");
        step(0, 3'b100, 3'b000, 3'b000, 0, "R3 pending cleared after pair");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R2 idle");
        step(0, 3'b001, 3'b000, 3'b010, 0, "R3 pair 2,0");
        // R4 simultaneous pairs
        step(0, 3'b011, 3'b000, 3'b100, 0, "R4 same-cycle 0,1");
        step(0, 3'b110, 3'b000, 3'b001, 0, "R4 same-cycle 1,2");
        step(0, 3'b101, 3'b000, 3'b010, 0, "R4 same-cycle 0,2");
        // R5 all three together
        step(0, 3'b111, 3'b000, 3'b100, 0, "R5 triple picks 0,1");
        step(0, 3'b010, 3'b000, 3'b001, 0, "R5 line 2 left pending");
        // R6 duplicate
        step(0, 3'b001, 3'b000, 3'b000, 0, "R2 lone event");
        step(0, 3'b001, 3'b000, 3'b000, 1, "R6 duplicate flagged");
        step(0, 3'b100, 3'b000, 3'b010, 0, "R6 duplicate ignored, pair once");
        step(0, 3'b001, 3'b000, 3'b000, 0, "R2 lone event");
        step(0, 3'b011, 3'b000, 3'b100, 1, "R6 duplicate with partner");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R6 nothing left pending");
        step(0, 3'b010, 3'b000, 3'b000, 0, "R6 line 0 not re-armed");
        step(0, 3'b100, 3'b000, 3'b001, 0, "R3 pair 1,2");
        // R7/R8/R9 single stuck line 1: succ=2, pred=0
        step(0, 3'b000, 3'b010, 3'b100, 0, "R7 mark line 1");
        step(0, 3'b000, 3'b000, 3'b100, 0, "R8 held level");
        step(0, 3'b000, 3'b000, 3'b100, 0, "R7 mark sticky");
        step(0, 3'b100, 3'b000, 3'b101, 0, "R9 succ event pulses pred");
        step(0, 3'b000, 3'b000, 3'b100, 0, "R8 held level");
        step(0, 3'b001, 3'b000, 3'b100, 0, "R9 pred event absorbed");
        step(0, 3'b011, 3'b000, 3'b100, 0, "R9 pred event absorbed");
        // R12 reset clears faults
        step(1, 3'b000, 3'b000, 3'b000, 0, "R12 reset clears marks");
        step(0, 3'b001, 3'b000, 3'b000, 0, "R12 healthy lone event");
        step(0, 3'b010, 3'b000, 3'b100, 0, "R12 healthy pair");
        // single stuck line 0: succ=1, pred=2
        step(0, 3'b000, 3'b001, 3'b010, 0, "R8 mark line 0 level");
        step(0, 3'b010, 3'b000, 3'b110, 0, "R9 succ event pulses pred");
        step(0, 3'b100, 3'b000, 3'b010, 0, "R9 pred event absorbed");
        step(1, 3'b000, 3'b000, 3'b000, 0, "R12 reset");
        // single stuck line 2: succ=0, pred=1
        step(0, 3'b000, 3'b100, 3'b001, 0, "R8 mark line 2 level");
        step(0, 3'b001, 3'b000, 3'b011, 0, "R9 succ event pulses pred");
        step(0, 3'b010, 3'b000, 3'b001, 0, "R9 pred event absorbed");
        // R10 two stuck: lines 0 and 2, free line 1
        step(0, 3'b000, 3'b001, 3'b010, 0, "R10 two marks level");
        step(0, 3'b010, 3'b000, 3'b010, 0, "R10 free-line event no effect");
        step(0, 3'b101, 3'b000, 3'b010, 0, "R10 events no effect");
        // R11 all stuck
        step(0, 3'b000, 3'b010, 3'b000, 0, "R11 all marked silent");
        step(0, 3'b111, 3'b000, 3'b000, 0, "R11 events no effect");
        step(0, 3'b010, 3'b000, 3'b000, 0, "R11 events no effect");
        // R12 recovery
        step(1, 3'b000, 3'b000, 3'b000, 0, "R12 reset");
        step(0, 3'b100, 3'b000, 3'b000, 0, "R12 healthy lone event");
        step(0, 3'b001, 3'b000, 3'b010, 0, "R12 healthy pair");
        step(0, 3'b000, 3'b000, 3'b000, 0, "R12 idle");
        @(negedge clk);
        ev_in   = '0;
        flt_set = '0;
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule